// File: doc/BRIEF.md
# Sensor Bridge Calibration Datapath

This block turns one raw bridge sample and one raw temperature sample into a calibrated bridge code and a calibrated temperature. The correction covers offset, gain, the drift of offset with temperature and the drift of gain with temperature. One extra second-order coefficient can bend exactly one of three quantities. A 2-bit mode input picks which one: the final bridge value, the offset drift, or the gain drift. A fourth mode turns the second-order term off.

A single start strobe captures the raw samples, the coefficients and the mode. A small sequencer then steps one shared signed multiplier through eight products, each rounded to nearest. A one-cycle done pulse marks the moment the new results appear. Every mode follows the same schedule, so the latency never changes. The bridge result is clamped into an 11-bit unsigned code. The temperature result is clamped into a signed 16-bit range.

Gains and drift coefficients are fixed-point values with FRAC = 12 fractional bits, so 4096 stands for 1.0. Raw samples, offsets and the temperature reference are plain integers.

Top module: `calib_datapath`

## Requirements
- R1: While reset is high and in the first cycle after it, done = 0, br_out = 0 and t_out = 0.
- R2: A start seen while the unit is idle is accepted at that clock edge. done is high for exactly one cycle, 8 rising edges after the accepting edge, in every mode.
- R3: A start seen while a computation is in progress has no effect. The running result is not disturbed, and no extra done pulse follows.
- R4: br_out and t_out change only in the cycle in which done is high. Otherwise they hold their values.
- R5: With mode = 2'b11 (no second-order term): dt = t_raw - t_ref, ofs = M(dt, tco), g = M(dt, tcg), y = M(4096 + g, br_raw + off_b + ofs), and br = M(gain_b, y).
- R6: With mode = 2'b01 (second-order term on offset drift): m = M(sot, dt) and ofs = M(dt, m + tco). All other terms are as in R5.
- R7: With mode = 2'b10 (second-order term on gain drift): m = M(sot, dt) and g = M(dt, m + tcg). All other terms are as in R5.
- R8: With mode = 2'b00 (second-order term on the bridge value): zb is the R5 result. Then q = M(zb, zb) and br = zb + M(sot, q).
- R9: The corrected temperature is t = M(gain_t, t_raw + off_t), in every mode.
- R10: Every product M(a, b) is (a*b + 2048) >> 12, with an arithmetic shift. An exact half therefore rounds toward plus infinity: 1.5 gives 2 and -1.5 gives -1.
- R11: br_out is br clamped to the range 0 to 2047. Values above 2047 give 2047 and negative values give 0.
- R12: t_out is t clamped to the range -32768 to 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a computation; captures all data inputs |
| mode | input | 2 | Second-order placement: 00 bridge, 01 offset drift, 10 gain drift, 11 none |
| br_raw | input | 16 | Raw bridge sample, signed |
| t_raw | input | 16 | Raw temperature sample, signed |
| gain_b | input | 16 | Bridge gain, signed, 12 fractional bits |
| off_b | input | 16 | Bridge offset, signed integer |
| tco | input | 16 | Offset drift coefficient, signed, 12 fractional bits |
| tcg | input | 16 | Gain drift coefficient, signed, 12 fractional bits |
| sot | input | 16 | Second-order coefficient, signed, 12 fractional bits |
| t_ref | input | 16 | Raw temperature reference, signed integer |
| gain_t | input | 16 | Temperature gain, signed, 12 fractional bits |
| off_t | input | 16 | Temperature offset, signed integer |
| done | output | 1 | One-cycle pulse: results updated |
| br_out | output | 11 | Calibrated bridge code, clamped |
| t_out | output | 16 | Calibrated temperature, signed, clamped |

## Verification
A wrong step counter shows up at the ports within one run. The done pulse arrives off its fixed 8-edge position, or a product lands in the wrong slot and corrupts br_out in a way that depends on the mode. A mode decode error is visible only in the mode it touches, so every mode is run with a non-zero second-order coefficient and compared against an independent model. A busy flag that re-arms on a late start produces a second done pulse, and often changed outputs, about eight cycles after that start.

// File: rtl/calib_pkg.sv
package calib_pkg;
  typedef enum logic [1:0] {
    SOT_BRIDGE = 2'b00,
    SOT_OFS    = 2'b01,
    SOT_GAIN   = 2'b10,
    SOT_NONE   = 2'b11
  } sot_mode_e;
endpackage

// File: rtl/calib_sat.sv
module calib_sat #(
  parameter int IW = 32,
  parameter int OW = 11,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic signed [IW-1:0] din,
  output logic        [OW-1:0] dout
);
  generate
    if (SIGNED_OUT) begin : g_signed
      localparam logic signed [IW-1:0] HI = (IW'(1) <<< (OW - 1)) - IW'(1);
      localparam logic signed [IW-1:0] LO = -(IW'(1) <<< (OW - 1));
      always_comb begin
        if (din > HI)      dout = HI[OW-1:0];
        else if (din < LO) dout = LO[OW-1:0];
        else               dout = din[OW-1:0];
      end
    end else begin : g_unsigned
      localparam logic signed [IW-1:0] HI = (IW'(1) <<< OW) - IW'(1);
      always_comb begin
        if (din > HI)            dout = HI[OW-1:0];
        else if (din < IW'(0))   dout = '0;
        else                     dout = din[OW-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/calib_mul.sv
module calib_mul #(
  parameter int W    = 32,
  parameter int FRAC = 12
) (
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int PW = 2 * W;
  localparam int HW = PW - FRAC;

  logic signed [PW-1:0] prod;
  logic signed [HW-1:0] rnd;
  logic        [W-1:0]  y_u;

  assign prod = a * b;
  // round half up: truncated quotient plus the first dropped bit
  assign rnd  = prod[PW-1:FRAC] + {{(HW-1){1'b0}}, prod[FRAC-1]};

  calib_sat #(.IW(HW), .OW(W), .SIGNED_OUT(1'b1)) u_sat (
    .din (rnd),
    .dout(y_u)
  );
  assign y = signed'(y_u);
endmodule

// File: rtl/calib_ctrl.sv
module calib_ctrl #(
  parameter int STEPS = 8,
  localparam int SW = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          last,
  output logic [SW-1:0] step
);
  localparam logic [SW-1:0] LAST_STEP = SW'(STEPS - 1);

  assign accept = start && !busy;
  assign last   = busy && (step == LAST_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      step <= '0;
    end else if (busy) begin
      if (step == LAST_STEP) busy <= 1'b0;
      else                   step <= step + SW'(1);
    end
  end
endmodule

// File: rtl/calib_datapath.sv
module calib_datapath
  import calib_pkg::*;
#(
  parameter int W_IN  = 16,
  parameter int W_ACC = 32,
  parameter int FRAC  = 12,
  parameter int OUT_W = 11,
  parameter int TMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic signed [W_IN-1:0]  br_raw,
  input  logic signed [W_IN-1:0]  t_raw,
  input  logic signed [W_IN-1:0]  gain_b,
  input  logic signed [W_IN-1:0]  off_b,
  input  logic signed [W_IN-1:0]  tco,
  input  logic signed [W_IN-1:0]  tcg,
  input  logic signed [W_IN-1:0]  sot,
  input  logic signed [W_IN-1:0]  t_ref,
  input  logic signed [W_IN-1:0]  gain_t,
  input  logic signed [W_IN-1:0]  off_t,
  output logic                    done,
  output logic [OUT_W-1:0]        br_out,
  output logic signed [TMP_W-1:0] t_out
);
  localparam int STEPS = 8;
  localparam int SW    = $clog2(STEPS);
  localparam int NIN   = 10;
  localparam logic signed [W_ACC-1:0] ONE = W_ACC'(1) <<< FRAC;

  // capture slots, indices into cap[]
  localparam int C_BR = 0, C_TR = 1, C_GB = 2, C_OB = 3, C_TCO = 4;
  localparam int C_TCG = 5, C_SOT = 6, C_TREF = 7, C_GT = 8, C_OT = 9;

  logic          accept, busy, last;
  logic [SW-1:0] step;

  calib_ctrl #(.STEPS(STEPS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .accept(accept), .busy(busy), .last(last), .step(step)
  );

  logic signed [W_IN-1:0]  din [NIN];
  logic signed [W_ACC-1:0] cap [NIN];
  sot_mode_e               mode_q;

  assign din[C_BR]   = br_raw;
  assign din[C_TR]   = t_raw;
  assign din[C_GB]   = gain_b;
  assign din[C_OB]   = off_b;
  assign din[C_TCO]  = tco;
  assign din[C_TCG]  = tcg;
  assign din[C_SOT]  = sot;
  assign din[C_TREF] = t_ref;
  assign din[C_GT]   = gain_t;
  assign din[C_OT]   = off_t;

  generate
    for (genvar i = 0; i < NIN; i++) begin : g_cap
      always_ff @(posedge clk) begin
        if (rst)         cap[i] <= '0;
        else if (accept) cap[i] <= W_ACC'(din[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         mode_q <= SOT_NONE;
    else if (accept) mode_q <= sot_mode_e'(mode);
  end

  // step results: 0 m, 1 ofs, 2 g, 3 y, 4 zb, 5 q, 6 r
  logic signed [W_ACC-1:0] res [STEPS-1];
  logic signed [W_ACC-1:0] op_a, op_b, prod, dt;

  assign dt = cap[C_TR] - cap[C_TREF];

  always_comb begin
    op_a = '0;
    op_b = '0;
    case (step)
      SW'(0): begin op_a = cap[C_SOT]; op_b = dt; end
      SW'(1): begin
        op_a = dt;
        op_b = cap[C_TCO] + ((mode_q == SOT_OFS) ? res[0] : '0);
      end
      SW'(2): begin
        op_a = dt;
        op_b = cap[C_TCG] + ((mode_q == SOT_GAIN) ? res[0] : '0);
      end
      SW'(3): begin op_a = ONE + res[2]; op_b = cap[C_BR] + cap[C_OB] + res[1]; end
      SW'(4): begin op_a = cap[C_GB]; op_b = res[3]; end
      SW'(5): begin op_a = res[4]; op_b = res[4]; end
      SW'(6): begin op_a = cap[C_SOT]; op_b = res[5]; end
      default: begin op_a = cap[C_GT]; op_b = cap[C_TR] + cap[C_OT]; end
    endcase
  end

  calib_mul #(.W(W_ACC), .FRAC(FRAC)) u_mul (.a(op_a), .b(op_b), .y(prod));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STEPS - 1; k++) res[k] <= '0;
    end else if (busy && !last) begin
      res[step] <= prod;
    end
  end

  logic signed [W_ACC-1:0] br_sum;
  logic [OUT_W-1:0]        br_sat;
  logic [TMP_W-1:0]        t_sat;

  assign br_sum = res[4] + ((mode_q == SOT_BRIDGE) ? res[6] : '0);

  calib_sat #(.IW(W_ACC), .OW(OUT_W), .SIGNED_OUT(1'b0)) u_sat_br (
    .din(br_sum), .dout(br_sat)
  );
  calib_sat #(.IW(W_ACC), .OW(TMP_W), .SIGNED_OUT(1'b1)) u_sat_t (
    .din(prod), .dout(t_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      br_out <= '0;
      t_out  <= '0;
    end else begin
      done <= last;
      if (last) begin
        br_out <= br_sat;
        t_out  <= signed'(t_sat);
      end
    end
  end
endmodule

// File: rtl/calib_datapath_chk.sv
module calib_datapath_chk #(
  parameter int OUT_W = 11,
  parameter int TMP_W = 16,
  parameter int SW    = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             done,
  input logic [OUT_W-1:0] br_out,
  input logic [TMP_W-1:0] t_out,
  input logic             busy,
  input logic [SW-1:0]    step
);
  localparam logic [SW-1:0] LAST_STEP = {SW{1'b1}};

  // R2: accepted start begins at step 0
  p_accept_r2: assert property (@(posedge clk) disable iff (rst)
    start && !busy |=> busy && step == '0);

  // R2: sequence advances one step per cycle
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    busy && step != LAST_STEP |=> busy && step == $past(step) + SW'(1));

  // R2: final step leads to done
  p_finish_r2: assert property (@(posedge clk) disable iff (rst)
    busy && step == LAST_STEP |=> done && !busy);

  // R2: done lasts one cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: start during a run does not restart the counter
  p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    busy && start && step != LAST_STEP |=> step != '0);

  // R4: outputs hold outside the done cycle
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(br_out) && $stable(t_out));

  // R2: done never overlaps a running computation
  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind calib_datapath calib_datapath_chk #(
  .OUT_W(OUT_W), .TMP_W(TMP_W), .SW(SW)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .br_out(br_out), .t_out(t_out), .busy(busy), .step(step)
);

// File: tb/calib_datapath_tb.sv
module calib_datapath_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] mode = 2'b11;
  logic signed [15:0] br_raw = '0, t_raw = '0, gain_b = '0, off_b = '0;
  logic signed [15:0] tco = '0, tcg = '0, sot = '0, t_ref = '0;
  logic signed [15:0] gain_t = '0, off_t = '0;
  logic done;
  logic [10:0] br_out;
  logic signed [15:0] t_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  calib_datapath u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .br_raw(br_raw), .t_raw(t_raw), .gain_b(gain_b), .off_b(off_b),
    .tco(tco), .tcg(tcg), .sot(sot), .t_ref(t_ref),
    .gain_t(gain_t), .off_t(off_t),
    .done(done), .br_out(br_out), .t_out(t_out)
  );

  typedef struct packed {
    logic [1:0] md;
    logic signed [15:0] br, tr, gb, ob, co, cg, so, tf, gt, ot;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'b11, 16'sd1000, 16'sd700, 16'sd4096, -16'sd100, 16'sd205, 16'sd41, 16'sd400, 16'sd500, 16'sd4096, -16'sd500},
    '{2'b01, 16'sd1000, 16'sd700, 16'sd4096, -16'sd100, 16'sd205, 16'sd41, 16'sd400, 16'sd500, 16'sd4096, -16'sd500},
    '{2'b10, 16'sd1000, 16'sd700, 16'sd4096, -16'sd100, 16'sd205, 16'sd41, 16'sd400, 16'sd500, 16'sd4096, -16'sd500},
    '{2'b00, 16'sd1000, 16'sd700, 16'sd4096, -16'sd100, 16'sd205, 16'sd41, -16'sd300, 16'sd500, 16'sd4096, -16'sd500},
    '{2'b11, 16'sd800, 16'sd300, 16'sd4915, 16'sd37, 16'sd205, 16'sd41, 16'sd0, 16'sd500, 16'sd5000, 16'sd20},
    '{2'b00, 16'sd1500, 16'sd600, 16'sd8192, 16'sd0, 16'sd100, 16'sd20, 16'sd400, 16'sd500, 16'sd4096, 16'sd0},
    '{2'b10, -16'sd500, 16'sd550, 16'sd4096, 16'sd0, 16'sd100, 16'sd20, 16'sd400, 16'sd500, 16'sd4096, 16'sd0},
    '{2'b01, 16'sd200, 16'sd20000, 16'sd4096, 16'sd0, 16'sd205, 16'sd41, 16'sd400, 16'sd500, 16'sd32767, 16'sd0},
    '{2'b11, 16'sd1200, -16'sd20000, 16'sd4096, 16'sd0, 16'sd205, 16'sd41, 16'sd400, 16'sd500, 16'sd32767, 16'sd0}
  };

  function automatic longint rm(longint a, longint b);
    return (a * b + 64'sd2048) >>> 12;
  endfunction

  function automatic longint clamp(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint model_br(vec_t v);
    longint dt, m, ofs, g, y, zb, q;
    dt  = longint'(v.tr) - longint'(v.tf);
    m   = rm(v.so, dt);
    ofs = rm(dt, longint'(v.co) + ((v.md == 2'b01) ? m : 0));
    g   = rm(dt, longint'(v.cg) + ((v.md == 2'b10) ? m : 0));
    y   = rm(4096 + g, longint'(v.br) + longint'(v.ob) + ofs);
    zb  = rm(v.gb, y);
    q   = rm(zb, zb);
    if (v.md == 2'b00) zb = zb + rm(v.so, q);
    return clamp(zb, 0, 2047);
  endfunction

  function automatic longint model_t(vec_t v);
    return clamp(rm(v.gt, longint'(v.tr) + longint'(v.ot)), -32768, 32767);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(vec_t v);
    mode = v.md; br_raw = v.br; t_raw = v.tr; gain_b = v.gb; off_b = v.ob;
    tco = v.co; tcg = v.cg; sot = v.so; t_ref = v.tf; gain_t = v.gt; off_t = v.ot;
  endtask

  // pulse start at a negedge, return edges until done is seen
  task automatic run(vec_t v, output int lat);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    vec_t v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done == 1'b0 && br_out == '0 && t_out == '0, "R1 reset", longint'(br_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && br_out == '0 && t_out == '0, "R1 after reset", longint'(t_out), 0);

    // table walk: R5 R6 R7 R8 R9 R11 R12 and latency R2
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run(v, lat);
      check(lat == 8, "R2 latency", lat, 8);
      check(longint'(br_out) == model_br(v), "R5/R6/R7/R8/R11 bridge", longint'(br_out), model_br(v));
      check(longint'(t_out) == model_t(v), "R9/R12 temperature", longint'(t_out), model_t(v));
      @(negedge clk);
      check(done == 1'b0, "R2 single pulse", longint'(done), 0);
    end

    // R11 boundaries by hand
    v = VEC[5];
    run(v, lat);
    check(br_out == 11'd2047, "R11 clamp high", longint'(br_out), 2047);
    v = VEC[6];
    run(v, lat);
    check(br_out == 11'd0, "R11 clamp low", longint'(br_out), 0);
    // R12 boundaries by hand
    v = VEC[7];
    run(v, lat);
    check(t_out == 16'sd32767, "R12 clamp high", longint'(t_out), 32767);
    v = VEC[8];
    run(v, lat);
    check(t_out == -16'sd32768, "R12 clamp low", longint'(t_out), -32768);

    // R10: half rounds up
    v = VEC[0];
    v.gt = 16'sd2048; v.tr = 16'sd3; v.ot = 16'sd0;
    run(v, lat);
    check(t_out == 16'sd2, "R10 +1.5", longint'(t_out), 2);
    v.tr = -16'sd3;
    run(v, lat);
    check(t_out == -16'sd1, "R10 -1.5", longint'(t_out), -1);

    // R4: hold after done
    repeat (5) @(negedge clk);
    check(t_out == -16'sd1 && done == 1'b0, "R4 hold", longint'(t_out), -1);

    // R3: late start with other data is ignored
    v = VEC[1];
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    apply(VEC[5]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 4;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 8, "R3 latency kept", lat, 8);
    check(longint'(br_out) == model_br(v), "R3 result kept", longint'(br_out), model_br(v));
    lat = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (done) lat++;
    end
    check(lat == 0, "R3 no extra done", lat, 0);
    check(longint'(br_out) == model_br(v), "R3 R4 outputs held", longint'(br_out), model_br(v));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule